// File: doc/BRIEF.md
# Hot-Plug Line Pulse Classifier

This block watches the hot-plug line on the transmitting side of a display link and sorts every low interval by its measured length. A resistor at the transmitter holds the line low when nothing is attached. An attached receiver drives the line high. While a receiver is attached, it can pull the line low briefly to signal something. The block measures each low interval and assigns it to one of three classes: a glitch (no event), an attention request from the receiver, or a disconnect.

The input is asynchronous, so it first passes through a multi-flop synchroniser. All thresholds are given in microseconds and are converted to clock cycles from a clock-frequency parameter, rounding up. The outputs are a level flag that shows an attached receiver, a one-cycle attention pulse and a one-cycle disconnect pulse. Servicing the attention request is left to the logic that consumes the pulse.

Top module: `hpd_pulse_classifier`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `attached_o`, `attn_o` and `detach_o` are all 0, whatever the level of `hpd_i`.
- R2: `attached_o` goes from 0 to 1 only after the synchronised line has been high for DEBOUNCE_US (100000 µs by default) without a break. Any low sample restarts that count.
- R3: While attached, a low interval shorter than GLITCH_US (250 µs) produces no pulse, and `attached_o` stays 1.
- R4: While attached, a low interval of at least GLITCH_US and at most DETACH_US (2000 µs) that ends with the line going high produces exactly one `attn_o` pulse, shortly after the rising edge. `attached_o` stays 1.
- R5: While attached, a low interval longer than DETACH_US produces exactly one `detach_o` pulse as soon as the low time passes DETACH_US, without waiting for the line to rise. `attached_o` drops to 0 in the same cycle.
- R6: While `attached_o` is 0, no low interval of any length produces an `attn_o` pulse.
- R7: `attn_o` and `detach_o` are each one cycle wide and are never high in the same cycle.
- R8: Each threshold in cycles is ceil(CLK_HZ × microseconds / 10^6), with a minimum of 1. The input passes through SYNC_STAGES (default 2) flops before it is classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hpd_i | input | 1 | Raw hot-plug line, asynchronous to `clk` |
| attached_o | output | 1 | 1 while a receiver is considered attached |
| attn_o | output | 1 | One-cycle pulse for an attention request |
| detach_o | output | 1 | One-cycle pulse when a disconnect is detected |

## Verification
A wrong state or a wrong duration counter shows up at the ports as a misclassified interval. Widths of one cycle below and one cycle above each boundary move a pulse from one output to the other, or make it vanish, within a few cycles of the rising edge. A wrong reload of the debounce counter shows up only much later, as `attached_o` rising too early or too late after a long high stretch that contains a short dip. A disconnect that waits for the rising edge is caught by sampling `detach_o` while the line is still held low.

// File: rtl/hpd_cls_pkg.sv
// Package: shared state encoding and threshold conversion for the
// hot-plug classifier. Assumes thresholds are given in microseconds.
package hpd_cls_pkg;

    // Classifier states: detached, attached with line high, attached with line low
    typedef enum logic [1:0] {
        ST_DETACHED = 2'd0,
        ST_ATT_HIGH = 2'd1,
        ST_ATT_LOW  = 2'd2
    } hpd_state_e;

    // Convert a duration in microseconds to clock cycles, rounding up, at least 1
    function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                     longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999999) / 64'd1000000;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/hpd_sync.sv
// Module: hpd_sync
// Brings the asynchronous hot-plug line into the clock domain through a
// chain of STAGES flops. Assumes STAGES >= 2. Resets to low, which matches
// the idle (nothing attached) level of the line.
module hpd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hpd_dur_timer.sv
// Module: hpd_dur_timer
// Saturating duration counter with threshold comparators. The controller
// clears it at the start of each measured level and advances it by one per
// sample. Assumes each threshold fits in W bits and is below the saturation value.
module hpd_dur_timer #(
    parameter int unsigned W          = 8,
    parameter int unsigned GLITCH_CYC = 10,
    parameter int unsigned DETACH_CYC = 80,
    parameter int unsigned DEB_CYC    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,          // restart the count
    input  logic inc_i,          // count this sample (applies after clear)
    output logic glitch_ok_o,    // count has reached the glitch limit
    output logic detach_hit_o,   // count equals the detach limit
    output logic deb_hit_o       // this sample completes the debounce time
);

    localparam logic [W-1:0] CNT_MAX   = '1;
    localparam logic [W-1:0] GLITCH_LV = W'(GLITCH_CYC);
    localparam logic [W-1:0] DETACH_LV = W'(DETACH_CYC);
    localparam logic [W-1:0] DEB_LV    = W'(DEB_CYC - 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    // Next count: clear, then optionally count the current sample, saturating
    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = inc_i ? W'(1) : '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    // Hold the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign glitch_ok_o  = (cnt_q >= GLITCH_LV);
    assign detach_hit_o = (cnt_q == DETACH_LV);
    assign deb_hit_o    = (cnt_q == DEB_LV);

    // R8: a clear with no count leaves the counter at zero on the next cycle
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !inc_i) |=> (cnt_q == '0));

    // R8: counting never wraps back to zero from a non-zero value
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_q != '0) |=> (cnt_q != '0));

endmodule

// File: rtl/hpd_cls_fsm.sv
// Module: hpd_cls_fsm
// Control for the classifier. It tracks the attached/detached state, drives
// the duration timer and registers the attention and disconnect pulses.
// Assumes line_i is already synchronised.
module hpd_cls_fsm
    import hpd_cls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic glitch_ok_i,
    input  logic detach_hit_i,
    input  logic deb_hit_i,
    output logic tmr_clr_o,
    output logic tmr_inc_o,
    output logic attached_o,
    output logic attn_o,
    output logic detach_o
);

    hpd_state_e state_q, state_d;
    logic       att_q, att_d;
    logic       attn_q, attn_d;
    logic       det_q, det_d;

    // Next state, timer commands and pulse requests for the current sample
    always_comb begin
        state_d   = state_q;
        att_d     = att_q;
        attn_d    = 1'b0;
        det_d     = 1'b0;
        tmr_clr_o = 1'b0;
        tmr_inc_o = 1'b0;
        unique case (state_q)
            ST_DETACHED: begin
                if (!line_i) begin
                    tmr_clr_o = 1'b1;
                end else if (deb_hit_i) begin
                    state_d   = ST_ATT_HIGH;
                    att_d     = 1'b1;
                    tmr_clr_o = 1'b1;
                end else begin
                    tmr_inc_o = 1'b1;
                end
            end
            ST_ATT_HIGH: begin
                tmr_clr_o = 1'b1;
                if (!line_i) begin
                    state_d   = ST_ATT_LOW;
                    tmr_inc_o = 1'b1;
                end
            end
            ST_ATT_LOW: begin
                if (!line_i) begin
                    if (detach_hit_i) begin
                        state_d   = ST_DETACHED;
                        att_d     = 1'b0;
                        det_d     = 1'b1;
                        tmr_clr_o = 1'b1;
                    end else begin
                        tmr_inc_o = 1'b1;
                    end
                end else begin
                    attn_d    = glitch_ok_i;
                    state_d   = ST_ATT_HIGH;
                    tmr_clr_o = 1'b1;
                end
            end
            default: begin
                state_d   = ST_DETACHED;
                att_d     = 1'b0;
                tmr_clr_o = 1'b1;
            end
        endcase
    end

    // State and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DETACHED;
            att_q   <= 1'b0;
            attn_q  <= 1'b0;
            det_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            att_q   <= att_d;
            attn_q  <= attn_d;
            det_q   <= det_d;
        end
    end

    assign attached_o = att_q;
    assign attn_o     = attn_q;
    assign detach_o   = det_q;

    // R2: the attached flag rises only after a high sample
    p_attach_on_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(att_q) |-> $past(line_i));

    // R5: the attached flag falls only together with a disconnect pulse
    p_drop_with_detach_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(att_q) |-> det_q);

    // R5: a disconnect is detected while the line is still low
    p_detach_while_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q) |-> !$past(line_i));

    // R6: an attention pulse appears only while attached
    p_attn_attached_r6: assert property (@(posedge clk) disable iff (!rst_n)
        attn_q |-> att_q);

    // R7: the two pulses are never high together
    p_excl_pulses_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(attn_q && det_q));

    // R7: the attention pulse lasts one cycle
    p_attn_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        attn_q |=> !attn_q);

    // R7: the disconnect pulse lasts one cycle
    p_detach_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        det_q |=> !det_q);

endmodule

// File: rtl/hpd_pulse_classifier.sv
// Module: hpd_pulse_classifier (top)
// Classifies low intervals on the hot-plug line as glitch, attention request
// or disconnect. Thresholds come from CLK_HZ and the *_US parameters.
// Assumes GLITCH_US < DETACH_US and a clock of at least a few kHz.
module hpd_pulse_classifier
    import hpd_cls_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 250_000_000,
    parameter int unsigned GLITCH_US   = 250,
    parameter int unsigned DETACH_US   = 2000,
    parameter int unsigned DEBOUNCE_US = 100_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hpd_i,
    output logic attached_o,
    output logic attn_o,
    output logic detach_o
);

    localparam int unsigned GLITCH_CYC = int'(us_to_cycles(CLK_HZ, GLITCH_US));
    localparam int unsigned DETACH_CYC = int'(us_to_cycles(CLK_HZ, DETACH_US));
    localparam int unsigned DEB_CYC    = int'(us_to_cycles(CLK_HZ, DEBOUNCE_US));
    localparam int unsigned MAX_CYC    = (DETACH_CYC > DEB_CYC) ? DETACH_CYC : DEB_CYC;
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 2);

    logic line_s;
    logic tmr_clr, tmr_inc;
    logic glitch_ok, detach_hit, deb_hit;

    hpd_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hpd_i),
        .q_o   (line_s)
    );

    hpd_dur_timer #(
        .W          (CNT_W),
        .GLITCH_CYC (GLITCH_CYC),
        .DETACH_CYC (DETACH_CYC),
        .DEB_CYC    (DEB_CYC)
    ) tmr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (tmr_clr),
        .inc_i        (tmr_inc),
        .glitch_ok_o  (glitch_ok),
        .detach_hit_o (detach_hit),
        .deb_hit_o    (deb_hit)
    );

    hpd_cls_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_s),
        .glitch_ok_i  (glitch_ok),
        .detach_hit_i (detach_hit),
        .deb_hit_i    (deb_hit),
        .tmr_clr_o    (tmr_clr),
        .tmr_inc_o    (tmr_inc),
        .attached_o   (attached_o),
        .attn_o       (attn_o),
        .detach_o     (detach_o)
    );

    // R1: all outputs are quiet on the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!attached_o && !attn_o && !detach_o));

endmodule

// File: tb/hpd_pulse_classifier_tb.sv
// Bench for hpd_pulse_classifier. CLK_HZ = 40000 scales the thresholds to
// 10 (glitch), 80 (detach) and 4000 (debounce) cycles.
module hpd_pulse_classifier_tb_top;

    localparam int unsigned TB_HZ   = 40_000;
    localparam int unsigned DEB     = 4000;
    localparam int unsigned NVEC    = 9;

    // Low width in cycles, expected attention pulses, expected disconnect pulses
    localparam int unsigned VEC_LOW [NVEC] = '{1, 3, 9, 10, 11, 40, 80, 81, 150};
    localparam int unsigned VEC_ATT [NVEC] = '{0, 0, 0, 1, 1, 1, 1, 0, 0};
    localparam int unsigned VEC_DET [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hpd_i = 1'b0;
    logic attached_o, attn_o, detach_o;

    int total = 0;
    int bad = 0;
    int attn_seen = 0;
    int det_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hpd_pulse_classifier #(
        .CLK_HZ (TB_HZ)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hpd_i      (hpd_i),
        .attached_o (attached_o),
        .attn_o     (attn_o),
        .detach_o   (detach_o)
    );

    // Count pulse cycles away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (attn_o)   attn_seen <= attn_seen + 1;
            if (detach_o) det_seen  <= det_seen + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int n);
        @(negedge clk);
        hpd_i = lvl;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a0, d0;
        // R1: reset with the line high
        hpd_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 attached in reset", int'(attached_o), 0);
        chk("R1 attn in reset", int'(attn_o), 0);
        chk("R1 detach in reset", int'(detach_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 attached after release", int'(attached_o), 0);

        // R2: attach only after the debounce time
        repeat (100) @(negedge clk);
        chk("R2 early attach", int'(attached_o), 0);
        repeat (DEB - 100 + 20) @(negedge clk);
        chk("R2 attach after debounce", int'(attached_o), 1);

        // Table walk: R3 glitch, R4 attention, R5 disconnect, R7 pulse widths
        for (int i = 0; i < NVEC; i++) begin
            a0 = attn_seen;
            d0 = det_seen;
            drive(1'b0, int'(VEC_LOW[i]));
            drive(1'b1, 20);
            chk($sformatf("R4 R7 attn count low=%0d", VEC_LOW[i]),
                attn_seen - a0, int'(VEC_ATT[i]));
            chk($sformatf("R5 R7 detach count low=%0d", VEC_LOW[i]),
                det_seen - d0, int'(VEC_DET[i]));
            chk($sformatf("R3 attached after low=%0d", VEC_LOW[i]),
                int'(attached_o), (VEC_DET[i] != 0) ? 0 : 1);
            if (VEC_DET[i] != 0) begin
                drive(1'b1, DEB + 20);
                chk("R2 reattach after detach", int'(attached_o), 1);
            end
        end

        // R5: disconnect fires while the line is still low
        d0 = det_seen;
        drive(1'b0, 70);
        chk("R5 no detach at 70 low", det_seen - d0, 0);
        chk("R5 still attached at 70 low", int'(attached_o), 1);
        repeat (30) @(negedge clk);
        chk("R5 detach while still low", det_seen - d0, 1);
        chk("R5 detached while still low", int'(attached_o), 0);

        // R6: attention-length pulse while detached gives nothing
        a0 = attn_seen;
        drive(1'b1, 50);
        drive(1'b0, 20);
        drive(1'b1, 20);
        chk("R6 attn while detached", attn_seen - a0, 0);
        chk("R6 stays detached", int'(attached_o), 0);

        // R2: a short dip restarts the debounce count
        drive(1'b0, 5);
        drive(1'b1, 3000);
        chk("R2 no attach after dip", int'(attached_o), 0);
        repeat (1100) @(negedge clk);
        chk("R2 attach after full high run", int'(attached_o), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule